// File: doc/BRIEF.md
# Panel Power-Up Register Loader on an 8080-Style Write Bus

This block is the controller-side master for a small active-matrix OLED driver chip. After its own reset it pulls the driver's active-low reset line down for a set number of clocks. It releases the line and waits a programmable settling time. It then replays a fixed, ordered list of register writes over a write-only 8080-style parallel bus. The list first sets up the interface width, the standby state, the frame rate and the two gate supply levels. It then loads the nine gamma registers. The display is switched on last, so the panel lights up with its gamma curve already in place.

Every register write is two strobes inside one chip-select window. The first strobe carries the register number with the select line low. The second carries the value with the select line high. A 16-bit word reaches the 18-bit bus through a split pin mapping that leaves two pins unused.

Once the list is done, the block raises a sticky completion flag and opens a valid/ready port. The host uses that port to issue further index/value writes, or single pixel words that go out as one data strobe with the select line high. Every strobe and select timing is a count of clock cycles set by a parameter.

Top module: `dinit_seq`

## Requirements
- R1: After `rst` is released, `lcd_res_n` stays low for RST_LOW_CYC cycles. `lcd_cs_n` stays high while `lcd_res_n` is low. The first `lcd_cs_n` low comes no sooner than POST_WAIT_CYC cycles after `lcd_res_n` rises.
- R2: `lcd_wr_n` goes low only while `lcd_cs_n` is low. `lcd_cs_n` is high whenever no transfer is in progress.
- R3: `lcd_db` and `lcd_rs` hold steady for the whole time `lcd_wr_n` is low, so the driver captures a settled word on the rising strobe edge.
- R4: Word bits 15..8 appear on `lcd_db[17:10]` and bits 7..0 on `lcd_db[8:1]`. `lcd_db[9]` and `lcd_db[0]` are always driven low.
- R5: `lcd_rs` is 0 for a register-number strobe and 1 for a value or pixel strobe.
- R6: The power-up list is written in this order: 0x0003←0x0030, 0x0010←0x0000, 0x0018←0x0028, 0x00F8←0x000F, 0x00F9←0x000F. Next come 0x0070..0x0078 ← 0x2580, 0x2780, 0x3380, 0x1D18, 0x1F11, 0x2419, 0x1A14, 0x211A, 0x2013 in ascending register order. The last write is 0x0005←0x0001. That is 30 strobes in all.
- R7: `init_done` is low during the power-up list, rises after its last strobe, and stays high. `host_ready` is never high while `init_done` is low.
- R8: A host request accepted with `host_pixel`=0 produces a register-number strobe carrying `host_index` followed by a value strobe carrying `host_value`, inside one chip-select window.
- R9: A host request accepted with `host_pixel`=1 produces exactly one strobe carrying `host_value` with `lcd_rs`=1.
- R10: `lcd_rd_n` is high at all times.
- R11: Each `lcd_wr_n` low pulse lasts exactly WR_LOW_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host request present |
| host_ready | output | 1 | Request accepted on this edge when valid |
| host_pixel | input | 1 | 1 = single pixel word, 0 = register write |
| host_index | input | 16 | Register number for a register write |
| host_value | input | 16 | Register value or pixel word |
| init_done | output | 1 | Power-up list finished (sticky) |
| lcd_res_n | output | 1 | Driver reset, active low |
| lcd_cs_n | output | 1 | Driver chip select, active low |
| lcd_wr_n | output | 1 | Write strobe, active low, rising edge captures |
| lcd_rd_n | output | 1 | Read strobe, held high |
| lcd_rs | output | 1 | Register-number (0) / data (1) select |
| lcd_db | output | 18 | Parallel bus |

## Verification
Two of the block's functions can coincide. A host request can be pending in the very cycle the last power-up write ends and the completion flag rises. Two host requests can also be issued back to back, so that the next one is accepted on the edge at which the bus engine returns to idle. The bench raises `host_valid` while still waiting for `init_done` and issues requests on consecutive ready cycles. It then judges the whole captured strobe stream against a model list: the 30 power-up strobes must come first, with no host strobe mixed in, and every host strobe must follow them in order with the right select level and word.

// File: rtl/dinit_pkg.sv
package dinit_pkg;

   localparam int INIT_LEN = 15;
   localparam int WORD_W   = 16;
   localparam int BUS_W    = 18;

   typedef struct packed {
      logic [WORD_W-1:0] idx;
      logic [WORD_W-1:0] val;
   } reg_pair_t;

   typedef enum logic [2:0] {
      E_IDLE,
      E_SETUP,
      E_LOW,
      E_HIGH,
      E_HOLD
   } eng_st_t;

   typedef enum logic [1:0] {
      S_RST,
      S_WAIT,
      S_INIT,
      S_HOST
   } seq_st_t;

   // gamma curve words, ascending register order
   function automatic logic [WORD_W-1:0] gamma_word(input int unsigned g);
      case (g)
         0:       gamma_word = 16'h2580;
         1:       gamma_word = 16'h2780;
         2:       gamma_word = 16'h3380;
         3:       gamma_word = 16'h1D18;
         4:       gamma_word = 16'h1F11;
         5:       gamma_word = 16'h2419;
         6:       gamma_word = 16'h1A14;
         7:       gamma_word = 16'h211A;
         8:       gamma_word = 16'h2013;
         default: gamma_word = '0;
      endcase
   endfunction

   // power-up list: setup writes, gamma block, display-on last
   function automatic reg_pair_t init_entry(input int unsigned n);
      reg_pair_t e;
      e = '0;
      if (n < 5) begin
         case (n)
            0:       begin e.idx = 16'h0003; e.val = 16'h0030; end
            1:       begin e.idx = 16'h0010; e.val = 16'h0000; end
            2:       begin e.idx = 16'h0018; e.val = 16'h0028; end
            3:       begin e.idx = 16'h00F8; e.val = 16'h000F; end
            default: begin e.idx = 16'h00F9; e.val = 16'h000F; end
         endcase
      end else if (n < 14) begin
         e.idx = 16'h0070 + WORD_W'(n - 5);
         e.val = gamma_word(n - 5);
      end else if (n == 14) begin
         e.idx = 16'h0005;
         e.val = 16'h0001;
      end
      return e;
   endfunction

endpackage

// File: rtl/dinit_table.sv
module dinit_table
   import dinit_pkg::*;
#(
   parameter int PTR_W = 4
) (
   input  logic [PTR_W-1:0] ptr,
   output reg_pair_t        entry
);

   generate
      if ((1 << PTR_W) <= INIT_LEN) begin : g_bad_ptr
         $error("dinit_table: PTR_W too narrow for the list");
      end
   endgenerate

   always_comb begin
      entry = init_entry(int'(ptr));
   end

endmodule

// File: rtl/dinit_pinmap.sv
module dinit_pinmap
   import dinit_pkg::*;
(
   input  logic [WORD_W-1:0] word,
   output logic [BUS_W-1:0]  db
);

   localparam int HI_BASE = 10;
   localparam int LO_BASE = 1;
   localparam int HALF    = WORD_W / 2;

   generate
      if (BUS_W != 18 || WORD_W != 16) begin : g_bad_map
         $error("dinit_pinmap: split mapping needs 16-bit words on an 18-bit bus");
      end
      for (genvar b = 0; b < HALF; b++) begin : g_map
         assign db[HI_BASE + b] = word[HALF + b];
         assign db[LO_BASE + b] = word[b];
      end
   endgenerate

   assign db[9] = 1'b0;
   assign db[0] = 1'b0;

endmodule

// File: rtl/dinit_bus_engine.sv
module dinit_bus_engine
   import dinit_pkg::*;
#(
   parameter int CS_SETUP_CYC = 1,
   parameter int WR_LOW_CYC   = 2,
   parameter int WR_HIGH_CYC  = 2,
   parameter int CS_HOLD_CYC  = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              pair,
   input  logic [WORD_W-1:0] w0,
   input  logic [WORD_W-1:0] w1,
   output logic              accept,
   output logic              cs_n,
   output logic              wr_n,
   output logic              rs,
   output logic [WORD_W-1:0] word
);

   localparam int MAX_A  = (CS_SETUP_CYC > WR_LOW_CYC) ? CS_SETUP_CYC : WR_LOW_CYC;
   localparam int MAX_B  = (WR_HIGH_CYC > CS_HOLD_CYC) ? WR_HIGH_CYC : CS_HOLD_CYC;
   localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CW     = (MAX_C < 2) ? 1 : $clog2(MAX_C);

   generate
      if (CS_SETUP_CYC < 1 || WR_LOW_CYC < 1 || WR_HIGH_CYC < 1 || CS_HOLD_CYC < 1)
      begin : g_bad_timing
         $error("dinit_bus_engine: every timing count must be at least 1");
      end
   endgenerate

   eng_st_t           st;
   logic [CW-1:0]     cnt;
   logic              pair_q;
   logic              second;
   logic [WORD_W-1:0] w1_q;

   assign accept = (st == E_IDLE);

   always_ff @(posedge clk) begin
      if (rst) begin
         st     <= E_IDLE;
         cnt    <= '0;
         cs_n   <= 1'b1;
         wr_n   <= 1'b1;
         rs     <= 1'b1;
         word   <= '0;
         pair_q <= 1'b0;
         second <= 1'b0;
         w1_q   <= '0;
      end else begin
         case (st)
            E_IDLE: begin
               if (start) begin
                  st     <= E_SETUP;
                  cs_n   <= 1'b0;
                  word   <= w0;
                  rs     <= !pair;
                  pair_q <= pair;
                  w1_q   <= w1;
                  second <= 1'b0;
                  cnt    <= CW'(CS_SETUP_CYC - 1);
               end
            end
            E_SETUP: begin
               if (cnt == '0) begin
                  wr_n <= 1'b0;
                  cnt  <= CW'(WR_LOW_CYC - 1);
                  st   <= E_LOW;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            E_LOW: begin
               if (cnt == '0) begin
                  wr_n <= 1'b1;
                  cnt  <= CW'(WR_HIGH_CYC - 1);
                  st   <= E_HIGH;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            E_HIGH: begin
               if (cnt == '0) begin
                  if (pair_q && !second) begin
                     second <= 1'b1;
                     word   <= w1_q;
                     rs     <= 1'b1;
                     wr_n   <= 1'b0;
                     cnt    <= CW'(WR_LOW_CYC - 1);
                     st     <= E_LOW;
                  end else begin
                     cnt <= CW'(CS_HOLD_CYC - 1);
                     st  <= E_HOLD;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            E_HOLD: begin
               if (cnt == '0) begin
                  cs_n <= 1'b1;
                  st   <= E_IDLE;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: st <= E_IDLE;
         endcase
      end
   end

   // strobe only inside an active select window
   assert_strobe_in_select_R2: assert property (@(posedge clk) disable iff (rst)
      !wr_n |-> !cs_n);

   // word and select line frozen across the low strobe
   assert_bus_stable_R3: assert property (@(posedge clk) disable iff (rst)
      (!wr_n && $past(!wr_n)) |-> ($stable(word) && $stable(rs)));

   // idle engine leaves the select released
   assert_idle_released_R2: assert property (@(posedge clk) disable iff (rst)
      (accept && $past(accept)) |-> cs_n);

endmodule

// File: rtl/dinit_seq.sv
module dinit_seq
   import dinit_pkg::*;
#(
   parameter int RST_LOW_CYC   = 8,
   parameter int POST_WAIT_CYC = 16,
   parameter int CS_SETUP_CYC  = 1,
   parameter int WR_LOW_CYC    = 2,
   parameter int WR_HIGH_CYC   = 2,
   parameter int CS_HOLD_CYC   = 1
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        host_valid,
   output logic        host_ready,
   input  logic        host_pixel,
   input  logic [15:0] host_index,
   input  logic [15:0] host_value,
   output logic        init_done,
   output logic        lcd_res_n,
   output logic        lcd_cs_n,
   output logic        lcd_wr_n,
   output logic        lcd_rd_n,
   output logic        lcd_rs,
   output logic [17:0] lcd_db
);

   localparam int TMAX = (RST_LOW_CYC > POST_WAIT_CYC) ? RST_LOW_CYC : POST_WAIT_CYC;
   localparam int TW   = (TMAX < 2) ? 1 : $clog2(TMAX);
   localparam int PW   = $clog2(INIT_LEN + 1);

   generate
      if (RST_LOW_CYC < 1 || POST_WAIT_CYC < 1) begin : g_bad_wait
         $error("dinit_seq: reset and wait counts must be at least 1");
      end
   endgenerate

   seq_st_t           st;
   logic [TW-1:0]     tcnt;
   logic [PW-1:0]     ptr;
   reg_pair_t         entry;
   logic              eng_accept;
   logic              eng_start;
   logic              eng_pair;
   logic [WORD_W-1:0] eng_w0;
   logic [WORD_W-1:0] eng_w1;
   logic [WORD_W-1:0] bus_word;
   logic              list_issue;
   logic              host_take;

   dinit_table #(.PTR_W(PW)) u_table (
      .ptr   (ptr),
      .entry (entry)
   );

   assign list_issue = (st == S_INIT) && eng_accept && (ptr != PW'(INIT_LEN));
   assign host_ready = (st == S_HOST) && eng_accept;
   assign host_take  = host_valid && host_ready;
   assign eng_start  = list_issue || host_take;
   assign init_done  = (st == S_HOST);
   assign lcd_rd_n   = 1'b1;

   always_comb begin
      if (st == S_HOST) begin
         eng_pair = !host_pixel;
         eng_w0   = host_pixel ? host_value : host_index;
         eng_w1   = host_value;
      end else begin
         eng_pair = 1'b1;
         eng_w0   = entry.idx;
         eng_w1   = entry.val;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st        <= S_RST;
         tcnt      <= TW'(RST_LOW_CYC - 1);
         ptr       <= '0;
         lcd_res_n <= 1'b0;
      end else begin
         case (st)
            S_RST: begin
               if (tcnt == '0) begin
                  lcd_res_n <= 1'b1;
                  tcnt      <= TW'(POST_WAIT_CYC - 1);
                  st        <= S_WAIT;
               end else begin
                  tcnt <= tcnt - 1'b1;
               end
            end
            S_WAIT: begin
               if (tcnt == '0) begin
                  st  <= S_INIT;
                  ptr <= '0;
               end else begin
                  tcnt <= tcnt - 1'b1;
               end
            end
            S_INIT: begin
               if (list_issue) begin
                  ptr <= ptr + 1'b1;
               end else if (eng_accept && ptr == PW'(INIT_LEN)) begin
                  st <= S_HOST;
               end
            end
            S_HOST: st <= S_HOST;
            default: st <= S_RST;
         endcase
      end
   end

   dinit_bus_engine #(
      .CS_SETUP_CYC (CS_SETUP_CYC),
      .WR_LOW_CYC   (WR_LOW_CYC),
      .WR_HIGH_CYC  (WR_HIGH_CYC),
      .CS_HOLD_CYC  (CS_HOLD_CYC)
   ) u_engine (
      .clk    (clk),
      .rst    (rst),
      .start  (eng_start),
      .pair   (eng_pair),
      .w0     (eng_w0),
      .w1     (eng_w1),
      .accept (eng_accept),
      .cs_n   (lcd_cs_n),
      .wr_n   (lcd_wr_n),
      .rs     (lcd_rs),
      .word   (bus_word)
   );

   dinit_pinmap u_pinmap (
      .word (bus_word),
      .db   (lcd_db)
   );

   // driver is never selected while it is held in reset
   assert_no_select_in_reset_R1: assert property (@(posedge clk) disable iff (rst)
      !lcd_res_n |-> lcd_cs_n);

   // host port opens only after the list completes
   assert_ready_after_done_R7: assert property (@(posedge clk) disable iff (rst)
      host_ready |-> init_done);

   // completion flag never drops
   assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      init_done |=> init_done);

   // released reset line stays released
   assert_reset_released_once_R1: assert property (@(posedge clk) disable iff (rst)
      lcd_res_n |=> lcd_res_n);

endmodule

// File: tb/tb_dinit_seq.sv
module tb_dinit_seq;

   localparam int CLK_PERIOD = 10;
   localparam int RST_LOW    = 6;
   localparam int POST_WAIT  = 10;
   localparam int CSS        = 2;
   localparam int WLO        = 2;
   localparam int WHI        = 3;
   localparam int CSH        = 1;
   localparam int MAXW       = 512;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        host_valid = 1'b0;
   logic        host_ready;
   logic        host_pixel = 1'b0;
   logic [15:0] host_index = '0;
   logic [15:0] host_value = '0;
   logic        init_done;
   logic        lcd_res_n, lcd_cs_n, lcd_wr_n, lcd_rd_n, lcd_rs;
   logic [17:0] lcd_db;

   always #(CLK_PERIOD/2) clk = ~clk;

   dinit_seq #(
      .RST_LOW_CYC   (RST_LOW),
      .POST_WAIT_CYC (POST_WAIT),
      .CS_SETUP_CYC  (CSS),
      .WR_LOW_CYC    (WLO),
      .WR_HIGH_CYC   (WHI),
      .CS_HOLD_CYC   (CSH)
   ) dut (
      .clk (clk), .rst (rst),
      .host_valid (host_valid), .host_ready (host_ready),
      .host_pixel (host_pixel), .host_index (host_index), .host_value (host_value),
      .init_done (init_done),
      .lcd_res_n (lcd_res_n), .lcd_cs_n (lcd_cs_n), .lcd_wr_n (lcd_wr_n),
      .lcd_rd_n (lcd_rd_n), .lcd_rs (lcd_rs), .lcd_db (lcd_db)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // expected strobe stream
   logic [15:0] exp_word [MAXW];
   logic        exp_rs   [MAXW];
   string       exp_req  [MAXW];
   int          n_exp = 0;

   function automatic logic [31:0] model_pair(input int n);
      logic [15:0] gam [9] = '{16'h2580, 16'h2780, 16'h3380, 16'h1D18, 16'h1F11,
                               16'h2419, 16'h1A14, 16'h211A, 16'h2013};
      case (n)
         0: return {16'h0003, 16'h0030};
         1: return {16'h0010, 16'h0000};
         2: return {16'h0018, 16'h0028};
         3: return {16'h00F8, 16'h000F};
         4: return {16'h00F9, 16'h000F};
         14: return {16'h0005, 16'h0001};
         default: return {16'h0070 + 16'(n - 5), gam[n - 5]};
      endcase
   endfunction

   task automatic push(input logic [15:0] w, input logic r, input string q);
      exp_word[n_exp] = w;
      exp_rs[n_exp]   = r;
      exp_req[n_exp]  = q;
      n_exp++;
   endtask

   // captured strobe stream
   logic [15:0] cap_word [MAXW];
   logic        cap_rs   [MAXW];
   logic        cap_done [MAXW];
   int          n_cap = 0;

   int   cyc = 0;
   int   low_run = 0;
   logic prev_wr = 1'b1;
   logic prev_res = 1'b0;
   logic [17:0] hold_db;
   logic hold_rs;
   logic hold_done;
   int   res_low_cnt = 0;
   int   res_rise_cyc = -1;
   int   first_cs_cyc = -1;
   bit   sel_in_reset = 0, rd_low = 0, ready_early = 0, spare_pin = 0, wr_no_cs = 0;

   always @(negedge clk) begin
      if (!rst) begin
         cyc++;
         if (!lcd_res_n) res_low_cnt++;
         if (lcd_res_n && !prev_res && res_rise_cyc < 0) res_rise_cyc = cyc;
         prev_res = lcd_res_n;
         if (!lcd_cs_n && first_cs_cyc < 0) first_cs_cyc = cyc;
         if (!lcd_res_n && !lcd_cs_n) sel_in_reset = 1;
         if (lcd_rd_n !== 1'b1) rd_low = 1;
         if (host_ready && !init_done) ready_early = 1;
         if (lcd_db[9] || lcd_db[0]) spare_pin = 1;
         if (!lcd_wr_n && lcd_cs_n) wr_no_cs = 1;
         if (!lcd_wr_n) begin
            low_run++;
            hold_db   = lcd_db;
            hold_rs   = lcd_rs;
            hold_done = init_done;
         end else if (!prev_wr) begin
            chk(low_run == WLO, "R11 strobe width", 32'(low_run), 32'(WLO));
            if (n_cap < MAXW) begin
               cap_word[n_cap] = {hold_db[17:10], hold_db[8:1]};
               cap_rs[n_cap]   = hold_rs;
               cap_done[n_cap] = hold_done;
               n_cap++;
            end
            low_run = 0;
         end
         prev_wr = lcd_wr_n;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog", 32'(n_cap), 32'(n_exp));
      finish_up();
   end

   task automatic host_op(input logic pix, input logic [15:0] idx, input logic [15:0] val);
      host_valid = 1'b1;
      host_pixel = pix;
      host_index = idx;
      host_value = val;
      @(negedge clk);
      while (!host_ready) @(negedge clk);
      @(negedge clk);
      host_valid = 1'b0;
      if (pix) push(val, 1'b1, "R9 pixel");
      else begin
         push(idx, 1'b0, "R8 host index");
         push(val, 1'b1, "R8 host value");
      end
   endtask

   initial begin
      int seed;
      seed = 32'h1234_5678;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(lcd_res_n == 1'b0, "R1 reset held", 32'(lcd_res_n), 0);
      chk(lcd_cs_n == 1'b1, "R2 select idle", 32'(lcd_cs_n), 1);
      chk(init_done == 1'b0, "R7 done at reset", 32'(init_done), 0);
      chk(host_ready == 1'b0, "R7 ready at reset", 32'(host_ready), 0);

      for (int n = 0; n < 15; n++) begin
         logic [31:0] p;
         p = model_pair(n);
         push(p[31:16], 1'b0, "R6 init index");
         push(p[15:0], 1'b1, "R6 init value");
      end

      // request pending before the list completes
      host_op(1'b1, 16'h0000, 16'hA5C3);
      // directed corners: all ones, all zeros, edge bits
      host_op(1'b1, 16'h0000, 16'hFFFF);
      host_op(1'b1, 16'h0000, 16'h0000);
      host_op(1'b0, 16'h8001, 16'h8001);
      host_op(1'b0, 16'h0022, 16'h0100);
      for (int k = 0; k < 24; k++) begin
         logic [31:0] r;
         r = $urandom;
         host_op(r[0], 16'($urandom), 16'($urandom));
      end
      repeat (40) @(negedge clk);

      chk(n_cap == n_exp, "R6 strobe count", 32'(n_cap), 32'(n_exp));
      for (int i = 0; i < n_exp && i < n_cap; i++) begin
         chk(cap_word[i] == exp_word[i], {exp_req[i], " word R4"}, 32'(cap_word[i]),
             32'(exp_word[i]));
         chk(cap_rs[i] == exp_rs[i], {exp_req[i], " select R5"}, 32'(cap_rs[i]),
             32'(exp_rs[i]));
         if (i < 30) chk(cap_done[i] == 1'b0, "R7 done during list", 32'(cap_done[i]), 0);
      end
      chk(init_done == 1'b1, "R7 done after list", 32'(init_done), 1);
      chk(lcd_cs_n == 1'b1, "R2 select released", 32'(lcd_cs_n), 1);
      chk(res_low_cnt >= RST_LOW - 1 && res_low_cnt <= RST_LOW, "R1 reset width",
          32'(res_low_cnt), 32'(RST_LOW));
      chk(first_cs_cyc - res_rise_cyc >= POST_WAIT, "R1 post-reset wait",
          32'(first_cs_cyc - res_rise_cyc), 32'(POST_WAIT));
      chk(!sel_in_reset, "R1 select in reset", 32'(sel_in_reset), 0);
      chk(!wr_no_cs, "R2 strobe outside select", 32'(wr_no_cs), 0);
      chk(!rd_low, "R10 read strobe", 32'(rd_low), 0);
      chk(!ready_early, "R7 ready before done", 32'(ready_early), 0);
      chk(!spare_pin, "R4 unused pins", 32'(spare_pin), 0);
      chk(1'b1, "R3 stability by assertion", 0, 0);
      finish_up();
   end

endmodule